// File: doc/BRIEF.md
# Packet-Commit FIFO Buffer

A single-clock FIFO that hands data to its reader only in whole packets. The writer pushes words one at a time and raises a commit strobe together with the last word of each packet. The reader sees nothing of a packet while it is still being written. Once the final word is committed, the whole packet becomes visible at once. A reader can therefore start draining as soon as the buffer reports non-empty, knowing that the complete packet is already stored.

Two write pointers are kept. The live pointer tracks storage and decides when the buffer is full. The published pointer is copied from the live pointer on a commit, and it is the only write position the read side compares against. Every pointer carries one bit beyond the address width, so a completely full buffer and an empty one never share an encoding. Reads come from a registered memory port. Requests that cannot be served are dropped and reported with a one-cycle error pulse.

Top module: `pkt_commit_fifo`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `empty` is 1, `full` is 0, `ready_words` is 0, and `rd_valid`, `wr_err` and `rd_err` are 0.
- R2: Words written with `wr_commit` low leave `empty` and `ready_words` unchanged, so data that has not been committed cannot be read.
- R3: A write accepted with `wr_commit` high makes every word written up to and including it readable. On the next cycle, `ready_words` rises by the length of the packet.
- R4: `full` is 1 exactly when the accepted writes minus the accepted reads equal the depth, whether or not those words are committed. A write request while `full` is 1 does not store the word.
- R5: A write request while `full` is 1 produces `wr_err` = 1 on the next cycle only. If that request also carries `wr_commit`, the commit is dropped as well.
- R6: A read request while `empty` is 1 is ignored. It produces `rd_err` = 1 and `rd_valid` = 0 on the next cycle.
- R7: A read request accepted while `empty` is 0 presents the oldest committed word on `rd_data`, with `rd_valid` = 1, on the next cycle. Words leave in the order they were written.
- R8: `empty` becomes 1 in the cycle after a read takes the last committed word, even when uncommitted words remain stored.
- R9: `wr_commit` raised without `wr_en` has no effect. `empty` and `ready_words` stay as they were.
- R10: `ready_words` equals the number of committed words not yet read, in the range 0 to the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_commit | input | 1 | Marks the word being written as the last word of its packet |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Registered read data |
| rd_valid | output | 1 | `rd_data` holds the word taken by the previous cycle's read |
| empty | output | 1 | No committed word is waiting |
| full | output | 1 | Storage is completely occupied |
| ready_words | output | ADDR_W+1 | Count of committed words not yet read |
| wr_err | output | 1 | One-cycle pulse: a write request was refused |
| rd_err | output | 1 | One-cycle pulse: a read request was refused |

## Verification
`full`, `empty` and `ready_words` are combinational functions of the pointer registers. They are checked in the same cycle as the request, before the clock edge that acts on it. `rd_data`, `rd_valid`, `wr_err` and `rd_err` are registered and fall due one edge after their request. The bench samples them at the falling edge that follows that rising edge, and it does so before it drives the next request. The bench keeps its own unbounded counts of writes, commits and reads, plus a shadow array. From these it derives the expected flags, the count and the data arithmetically, for every packet length from one word up to the full depth.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  // Distance from b forward to a on a wrapping counter of pw bits.
  function automatic int unsigned span(input int unsigned a, input int unsigned b,
                                       input int unsigned pw);
    int unsigned m;
    m = (32'd1 << pw) - 32'd1;
    return (a - b) & m;
  endfunction

  // The slot index that a pointer addresses, with its wrap bit removed.
  function automatic int unsigned slot(input int unsigned p, input int unsigned aw);
    return p & ((32'd1 << aw) - 32'd1);
  endfunction
endpackage

// File: rtl/pcf_store.sv
module pcf_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/pcf_wr_ctrl.sv
module pcf_wr_ctrl
  import pcf_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            wr_commit,
  input  logic [ADDR_W:0] rd_ptr,
  output logic [ADDR_W:0] live_ptr,
  output logic [ADDR_W:0] pub_ptr,
  output logic            full,
  output logic            wr_take,
  output logic            wr_err
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  assign full    = (span(32'(live_ptr), 32'(rd_ptr), PW) == DEPTH);
  assign wr_take = wr_en & ~full;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      live_ptr <= '0;
      pub_ptr  <= '0;
      wr_err   <= 1'b0;
    end else begin
      wr_err <= wr_en & full;
      if (wr_take) begin
        live_ptr <= live_ptr + 1'b1;
        if (wr_commit) pub_ptr <= live_ptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pcf_rd_ctrl.sv
module pcf_rd_ctrl
  import pcf_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_en,
  input  logic [ADDR_W:0] pub_ptr,
  output logic [ADDR_W:0] rd_ptr,
  output logic            empty,
  output logic            rd_take,
  output logic            rd_valid,
  output logic            rd_err,
  output logic [ADDR_W:0] ready_words
);
  localparam int PW = ADDR_W + 1;

  assign ready_words = PW'(span(32'(pub_ptr), 32'(rd_ptr), PW));
  assign empty       = (pub_ptr == rd_ptr);
  assign rd_take     = rd_en & ~empty;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rd_ptr   <= '0;
      rd_valid <= 1'b0;
      rd_err   <= 1'b0;
    end else begin
      rd_valid <= rd_take;
      rd_err   <= rd_en & empty;
      if (rd_take) rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/pkt_commit_fifo.sv
module pkt_commit_fifo #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_commit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              empty,
  output logic              full,
  output logic [ADDR_W:0]   ready_words,
  output logic              wr_err,
  output logic              rd_err
);
  logic [ADDR_W:0] live_ptr;
  logic [ADDR_W:0] pub_ptr;
  logic [ADDR_W:0] rd_ptr;
  logic            wr_take;
  logic            rd_take;

  pcf_wr_ctrl #(.ADDR_W(ADDR_W)) wr_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_commit(wr_commit), .rd_ptr(rd_ptr),
    .live_ptr(live_ptr), .pub_ptr(pub_ptr), .full(full), .wr_take(wr_take),
    .wr_err(wr_err)
  );

  pcf_rd_ctrl #(.ADDR_W(ADDR_W)) rd_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .pub_ptr(pub_ptr), .rd_ptr(rd_ptr),
    .empty(empty), .rd_take(rd_take), .rd_valid(rd_valid), .rd_err(rd_err),
    .ready_words(ready_words)
  );

  pcf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) mem_i (
    .clk(clk), .we(wr_take), .waddr(live_ptr[ADDR_W-1:0]), .wdata(wr_data),
    .re(rd_take), .raddr(rd_ptr[ADDR_W-1:0]), .rdata(rd_data)
  );
endmodule

// File: rtl/pcf_checker.sv
module pcf_checker #(
  parameter int ADDR_W = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            wr_en,
  input logic            wr_commit,
  input logic            rd_en,
  input logic            empty,
  input logic            full,
  input logic            rd_valid,
  input logic            wr_err,
  input logic            rd_err,
  input logic [ADDR_W:0] ready_words,
  input logic [ADDR_W:0] live_ptr,
  input logic [ADDR_W:0] pub_ptr
);
  localparam int DEPTH = 1 << ADDR_W;

  assert_hidden_partial_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_commit) |=> $stable(pub_ptr));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> $stable(live_ptr));

  assert_wr_err_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> wr_err);

  assert_rd_err_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> (rd_err && !rd_valid));

  assert_read_latency_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !empty) |=> rd_valid);

  assert_empty_count_R8: assert property (@(posedge clk) disable iff (rst)
    empty |-> (ready_words == '0));

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (rst)
    32'(ready_words) <= DEPTH);
endmodule

bind pkt_commit_fifo pcf_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_commit(wr_commit), .rd_en(rd_en),
  .empty(empty), .full(full), .rd_valid(rd_valid), .wr_err(wr_err), .rd_err(rd_err),
  .ready_words(ready_words), .live_ptr(live_ptr), .pub_ptr(pub_ptr)
);

// File: tb/pkt_commit_fifo_tb_top.sv
module pkt_commit_fifo_tb_top;
  localparam int DW = 8;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_commit = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_valid, empty, full, wr_err, rd_err;
  logic [AW:0] ready_words;

  int errors = 0;
  int checks = 0;
  int m_live = 0, m_pub = 0, m_rd = 0;
  int shadow [DEPTH];
  int seq = 1;
  bit finished = 0;

  always #10 clk = ~clk;

  pkt_commit_fifo #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_commit(wr_commit), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty), .full(full),
    .ready_words(ready_words), .wr_err(wr_err), .rd_err(rd_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 0; wr_commit = 0; rd_en = 0;
    @(negedge clk);
    chk(empty == 1 && full == 0 && ready_words == 0, "R1 flags in reset",
        {empty, full}, 2);
    @(negedge clk);
    rst = 1'b0;
    m_live = 0; m_pub = 0; m_rd = 0;
    @(negedge clk);
    chk(empty == 1 && full == 0 && ready_words == 0 && !rd_valid && !wr_err && !rd_err,
        "R1 state after reset", int'(ready_words), 0);
  endtask

  // One clock cycle; entered and left at a falling edge.
  task automatic cyc(input bit we, input bit cm, input bit re);
    bit xf, xe, wt, rt;
    int xc, xd;
    xf = (m_live - m_rd) == DEPTH;
    xe = (m_pub == m_rd);
    xc = m_pub - m_rd;
    wt = we && !xf;
    rt = re && !xe;
    xd = shadow[m_rd % DEPTH];
    wr_en = we; wr_commit = cm; rd_en = re; wr_data = DW'(seq);
    chk(full == xf, "R4 full flag", full, xf);
    chk(empty == xe, "R2/R8 empty flag", empty, xe);
    chk(int'(ready_words) == xc, "R10 ready_words", int'(ready_words), xc);
    @(posedge clk);
    @(negedge clk);
    chk(rd_valid == rt, "R7 rd_valid", rd_valid, rt);
    if (rt) chk(int'(rd_data) == xd, "R7 rd_data order", int'(rd_data), xd);
    chk(wr_err == (we && xf), "R5 wr_err", wr_err, we && xf);
    chk(rd_err == (re && xe), "R6 rd_err", rd_err, re && xe);
    if (wt) begin
      shadow[m_live % DEPTH] = seq & 8'hFF;
      m_live++;
      seq++;
      if (cm) m_pub = m_live;
    end
    if (rt) m_rd++;
    wr_en = 0; wr_commit = 0; rd_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    // Every packet length, written then fully drained plus one extra read.
    for (int len = 1; len <= DEPTH; len++) begin
      for (int k = 0; k < len; k++) begin
        cyc(1'b1, k == len - 1, 1'b0);
        if (k < len - 1)
          chk(empty == 1, "R2 partial packet hidden", empty, 1);
      end
      chk(empty == 0 && int'(ready_words) == len, "R3 commit publishes packet",
          int'(ready_words), len);
      for (int k = 0; k <= len; k++) cyc(1'b0, 1'b0, 1'b1);
      chk(empty == 1, "R8 empty after drain", empty, 1);
    end
    // A commit strobe with no write does nothing.
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    chk(empty == 1 && ready_words == 0, "R9 lone commit ignored", int'(ready_words), 0);
    cyc(1'b1, 1'b1, 1'b0);
    chk(int'(ready_words) == 4, "R3 packet of four", int'(ready_words), 4);
    // Read and write in the same cycles; the empty flag tracks only committed words.
    for (int k = 0; k < 6; k++) cyc(1'b1, k == 5, 1'b1);
    for (int k = 0; k < 9; k++) cyc(1'b0, 1'b0, 1'b1);
    // Committed full buffer; writes beyond are refused.
    for (int k = 0; k < DEPTH; k++) cyc(1'b1, k == DEPTH - 1, 1'b0);
    chk(full == 1 && int'(ready_words) == DEPTH, "R4 full at depth",
        int'(ready_words), DEPTH);
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b1, 1'b0, 1'b1);
    for (int k = 0; k < DEPTH + 1; k++) cyc(1'b0, 1'b0, 1'b1);
    // Full of uncommitted words; the overflowing commit is dropped.
    for (int k = 0; k < DEPTH; k++) cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    chk(empty == 1 && full == 1, "R5 dropped commit keeps data hidden", empty, 1);
    cyc(1'b0, 1'b0, 1'b1);
    do_reset();
    cyc(1'b1, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule